// File: doc/BRIEF.md
# Output Cell Buffer Bank with Age-Ordered Departure

This block holds the cells waiting at one output of a crossbar fabric. It has a small set of independent single-cell buffers, far fewer than the number of inputs. In one slot, several inputs can each write one cell into a different free buffer. Each write names its target buffer. The grant logic upstream picks that buffer, and the choice lies outside this block.

In every slot the block sends at most one cell toward the output queue, and it always sends the cell that has waited longest. Cells from one input can therefore sit in any buffers and still leave in arrival order. Each stored cell carries a slot tag taken when it was written. Cells written in the same slot leave in order of input index, lowest first.

The block also reports a credit count, which is the number of free buffers, for use by the grant logic. A write that is illegal is dropped and sets a sticky error flag. A write is illegal when its target buffer is occupied, when it loses a same-slot collision, or when it names a buffer that does not exist.

Top module: `cellBank`

## Requirements
- R1: After reset no buffer holds a cell, `credit` equals NUM_BUF (4), `outValid` is 0 and `errFlag` is 0.
- R2: A write to a free buffer stores the cell. On the next cycle `credit` is lower by the number of writes accepted in that slot.
- R3: Writes from several inputs in the same slot to distinct free buffers are all accepted.
- R4: At most one cell departs per slot. Whenever any buffer holds a cell at a clock edge, one cell departs at that edge and appears on `outValid`/`outData`/`outSrc` during the following cycle. With no cell held, `outValid` is 0.
- R5: The departing cell is always the one written in the earliest slot, whatever buffer index it occupies.
- R6: Among cells written in the same slot, the one from the lowest input index departs first.
- R7: A departing cell presents the payload that was written and its source input index on `outSrc`.
- R8: Each departure frees its buffer, so `credit` always equals the number of free buffers and rises by one per departure.
- R9: A write that targets a buffer holding a cell at that edge is dropped and sets `errFlag`. This includes a buffer whose cell departs at that same edge. Other cells are not disturbed.
- R10: When two inputs target the same free buffer in one slot, the lower input index is stored. The other write is dropped and sets `errFlag`.
- R11: `errFlag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NUM_IN | Per-input write strobe |
| inBuf | input | NUM_IN*BUF_W | Per-input target buffer index, input i in bits [i*BUF_W +: BUF_W] |
| inData | input | NUM_IN*DATA_W | Per-input cell payload, input i in bits [i*DATA_W +: DATA_W] |
| outValid | output | 1 | A cell is departing this cycle |
| outData | output | DATA_W | Payload of the departing cell |
| outSrc | output | IDX_W | Source input of the departing cell |
| credit | output | CNT_W | Number of free buffers |
| errFlag | output | 1 | Sticky illegal-write flag |

## Verification
A write and a departure can fall on the same edge, and on that edge they can even name the same buffer. The bench provokes this in two ways. First, it streams one cell per slot while alternating between two buffers, and it checks that the arrival order and a steady credit are kept. Second, it writes into a buffer on the very edge its previous cell leaves, and it checks that the new cell is dropped, the flag is raised and the departing cell still comes out intact. Same-slot ordering is judged by loading three inputs at once into scrambled buffer indices and checking the output sequence.

// File: rtl/bankPkg.sv
package bankPkg;
  localparam int NUM_IN  = 8;
  localparam int NUM_BUF = 4;
  localparam int IDX_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  // a held cell never waits more than NUM_BUF slots, so two extra bits cover its age
  localparam int TAG_W   = BUF_W + 2;
  localparam int CNT_W   = $clog2(NUM_BUF + 1);

  typedef struct packed {
    logic [NUM_BUF-1:0]            load;
    logic [NUM_BUF-1:0][IDX_W-1:0] loadSrc;
    logic [NUM_BUF-1:0]            pop;
    logic [TAG_W-1:0]              tag;
  } strobeT;
endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IN-1:0]             inValid,
  input  logic [NUM_IN*BUF_W-1:0]       inBuf,
  input  logic [NUM_BUF-1:0]            bufValid,
  input  logic [NUM_BUF-1:0][TAG_W-1:0] bufTag,
  input  logic [NUM_BUF-1:0][IDX_W-1:0] bufSrc,
  output strobeT                        strobe,
  output logic [CNT_W-1:0]              credit,
  output logic                          errFlag
);
  logic [TAG_W-1:0]   slotTag;
  logic [NUM_BUF-1:0] claimed;
  logic               errNow;
  logic               found;
  logic [BUF_W-1:0]   bestIdx;
  logic [TAG_W-1:0]   bestAge;
  logic [IDX_W-1:0]   bestSrc;
  logic [TAG_W-1:0]   age;
  logic [BUF_W-1:0]   tgt;
  logic [CNT_W-1:0]   held;

  // write claim: inputs scanned in index order, so the lowest wins a collision
  always_comb begin
    claimed        = '0;
    errNow         = 1'b0;
    strobe.loadSrc = '0;
    tgt            = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      tgt = inBuf[i*BUF_W +: BUF_W];
      if (inValid[i]) begin
        if (int'(tgt) >= NUM_BUF) begin
          errNow = 1'b1;
        end else if (bufValid[tgt] || claimed[tgt]) begin
          errNow = 1'b1;
        end else begin
          claimed[tgt]        = 1'b1;
          strobe.loadSrc[tgt] = IDX_W'(i);
        end
      end
    end
    strobe.load = claimed;
    strobe.tag  = slotTag;
  end

  // oldest-first pick: largest age, ties broken by lowest source index
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestAge = '0;
    bestSrc = '0;
    age     = '0;
    for (int k = 0; k < NUM_BUF; k++) begin
      age = slotTag - bufTag[k];
      if (bufValid[k] && (!found || age > bestAge ||
                          (age == bestAge && bufSrc[k] < bestSrc))) begin
        found   = 1'b1;
        bestIdx = BUF_W'(k);
        bestAge = age;
        bestSrc = bufSrc[k];
      end
    end
    for (int k = 0; k < NUM_BUF; k++) strobe.pop[k] = found && (bestIdx == BUF_W'(k));
  end

  always_comb begin
    held = '0;
    for (int k = 0; k < NUM_BUF; k++) held = held + CNT_W'(bufValid[k]);
    credit = CNT_W'(NUM_BUF) - held;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotTag <= '0;
      errFlag <= 1'b0;
    end else begin
      slotTag <= slotTag + 1'b1;
      if (errNow) errFlag <= 1'b1;
    end
  end

  p_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|bufValid) |-> (|strobe.pop));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

// File: rtl/bankData.sv
module bankData
  import bankPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IN*DATA_W-1:0]      inData,
  input  strobeT                        strobe,
  output logic [NUM_BUF-1:0]            bufValid,
  output logic [NUM_BUF-1:0][TAG_W-1:0] bufTag,
  output logic [NUM_BUF-1:0][IDX_W-1:0] bufSrc,
  output logic                          outValid,
  output logic [DATA_W-1:0]             outData,
  output logic [IDX_W-1:0]              outSrc
);
  logic [NUM_BUF-1:0][DATA_W-1:0] bufData;
  logic [DATA_W-1:0]              popData;
  logic [IDX_W-1:0]               popSrc;

  always_comb begin
    popData = '0;
    popSrc  = '0;
    for (int k = 0; k < NUM_BUF; k++) begin
      if (strobe.pop[k]) begin
        popData = bufData[k];
        popSrc  = bufSrc[k];
      end
    end
  end

  for (genvar k = 0; k < NUM_BUF; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufValid[k] <= 1'b0;
        bufData[k]  <= '0;
        bufSrc[k]   <= '0;
        bufTag[k]   <= '0;
      end else if (strobe.load[k]) begin
        bufValid[k] <= 1'b1;
        bufData[k]  <= inData[strobe.loadSrc[k]*DATA_W +: DATA_W];
        bufSrc[k]   <= strobe.loadSrc[k];
        bufTag[k]   <= strobe.tag;
      end else if (strobe.pop[k]) begin
        bufValid[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSrc   <= '0;
    end else begin
      outValid <= |strobe.pop;
      outData  <= popData;
      outSrc   <= popSrc;
    end
  end

  p_load_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load & bufValid) == '0);
  p_pop_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop & ~bufValid) == '0);
  p_out_from_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(|bufValid));
endmodule

// File: rtl/cellBank.sv
module cellBank
  import bankPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*BUF_W-1:0]  inBuf,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic [IDX_W-1:0]         outSrc,
  output logic [CNT_W-1:0]         credit,
  output logic                     errFlag
);
  strobeT                        strobe;
  logic [NUM_BUF-1:0]            bufValid;
  logic [NUM_BUF-1:0][TAG_W-1:0] bufTag;
  logic [NUM_BUF-1:0][IDX_W-1:0] bufSrc;

  bankCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBuf(inBuf),
    .bufValid(bufValid), .bufTag(bufTag), .bufSrc(bufSrc),
    .strobe(strobe), .credit(credit), .errFlag(errFlag)
  );

  bankData #(.DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe),
    .bufValid(bufValid), .bufTag(bufTag), .bufSrc(bufSrc),
    .outValid(outValid), .outData(outData), .outSrc(outSrc)
  );
endmodule

// File: tb/test_cellBank.sv
module test_cellBank;
  import bankPkg::*;
  localparam int DATA_W = 16;
  localparam time PERIOD = 10ns;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic [NUM_IN-1:0]        inValid = '0;
  logic [NUM_IN*BUF_W-1:0]  inBuf = '0;
  logic [NUM_IN*DATA_W-1:0] inData = '0;
  logic                     outValid;
  logic [DATA_W-1:0]        outData;
  logic [IDX_W-1:0]         outSrc;
  logic [CNT_W-1:0]         credit;
  logic                     errFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cellBank #(.DATA_W(DATA_W)) i_cellBank (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic putCell(int src, int b, int d);
    inValid[src] = 1'b1;
    inBuf[src*BUF_W +: BUF_W] = BUF_W'(b);
    inData[src*DATA_W +: DATA_W] = DATA_W'(d);
  endtask

  // inputs set just after a negedge; take one edge, clear, land on the next negedge
  task automatic stepSlot();
    @(posedge clk);
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic expectCell(string req, int src, int d);
    chk({req, " outValid"}, int'(outValid), 1);
    chk({req, " outSrc"}, int'(outSrc), src);
    chk({req, " outData"}, int'(outData), d);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 credit", int'(credit), NUM_BUF);
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 errFlag", int'(errFlag), 0);
  endtask

  task automatic t_parallel();
    putCell(5, 3, 16'h5555);
    putCell(1, 2, 16'h1111);
    putCell(3, 0, 16'h3333);
    stepSlot();
    chk("R2 R3 credit after three writes", int'(credit), 1);
    chk("R3 no error", int'(errFlag), 0);
    stepSlot();
    expectCell("R6 R7 first same-slot", 1, 16'h1111);
    chk("R8 credit after one departure", int'(credit), 2);
    stepSlot();
    expectCell("R6 second same-slot", 3, 16'h3333);
    stepSlot();
    expectCell("R6 third same-slot", 5, 16'h5555);
    chk("R8 credit all free", int'(credit), 4);
    stepSlot();
    chk("R4 idle outValid", int'(outValid), 0);
  endtask

  task automatic t_order();
    putCell(5, 3, 16'hA5);
    putCell(6, 2, 16'hA6);
    putCell(7, 1, 16'hA7);
    stepSlot();
    putCell(0, 0, 16'hB0);
    stepSlot();
    expectCell("R5 older slot first", 5, 16'hA5);
    stepSlot();
    expectCell("R5 older slot second", 6, 16'hA6);
    stepSlot();
    expectCell("R5 older slot third", 7, 16'hA7);
    stepSlot();
    expectCell("R5 newer slot last", 0, 16'hB0);
    stepSlot();
    chk("R4 drained", int'(outValid), 0);
    chk("R9 no error in legal traffic", int'(errFlag), 0);
  endtask

  task automatic t_stream();
    for (int n = 0; n < 6; n++) begin
      putCell(2, n % 2, 16'h100 + n);
      stepSlot();
      if (n > 0) expectCell("R4 R5 streamed cell", 2, 16'h100 + n - 1);
      if (n > 0) chk("R8 steady credit", int'(credit), NUM_BUF - 1);
    end
    stepSlot();
    expectCell("R4 last streamed cell", 2, 16'h105);
    chk("R9 stream legal", int'(errFlag), 0);
    stepSlot();
  endtask

  task automatic t_occupied();
    doReset();
    putCell(2, 1, 16'hC2);
    stepSlot();
    putCell(4, 1, 16'hC4);
    putCell(0, 2, 16'hC0);
    stepSlot();
    chk("R9 error on busy target", int'(errFlag), 1);
    expectCell("R9 departing cell intact", 2, 16'hC2);
    stepSlot();
    expectCell("R9 other write kept", 0, 16'hC0);
    stepSlot();
    chk("R9 dropped cell never leaves", int'(outValid), 0);
    chk("R9 credit all free", int'(credit), NUM_BUF);
    for (int n = 0; n < 3; n++) stepSlot();
    chk("R11 flag holds", int'(errFlag), 1);
  endtask

  task automatic t_collide();
    doReset();
    chk("R11 reset clears flag", int'(errFlag), 0);
    putCell(3, 0, 16'hD3);
    putCell(1, 0, 16'hD1);
    stepSlot();
    chk("R10 collision flagged", int'(errFlag), 1);
    chk("R10 one buffer taken", int'(credit), NUM_BUF - 1);
    stepSlot();
    expectCell("R10 lower input stored", 1, 16'hD1);
    stepSlot();
    chk("R10 loser dropped", int'(outValid), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_parallel();
    t_order();
    t_stream();
    t_occupied();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule